// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that gives a host a bank of general-purpose pins through exactly two registers: an output latch that the host writes and a port image that the host reads. No command or pointer byte is sent. Every pin is quasi-bidirectional. A latch bit of zero pulls its pin low. A latch bit of one releases the pin, so an outside source can set its level and the pin acts as an input. A read always returns the resolved pin levels and never the latch, so a pin that is pulled low cannot be told apart from an input that reads low. An active-low interrupt tells the host that an input has moved away from the value it last read. The pad is modelled as a resolved level on `pin_i`, and the pull-down request is driven on `pin_pull_o`.

SCL and SDA are oversampled by the system clock through two-flop synchronisers. An edge detector then turns them into SCL rise and fall events and START and STOP conditions. The transfer engine has eight states:
- **IDLE**: the bus is free.
- **ADDR**: shifts in the address byte.
- **ADDR_ACK**: drives the address acknowledge.
- **WR_DATA**: shifts in a write data byte.
- **WR_ACK**: drives the data acknowledge.
- **RD_DATA**: shifts out a port byte.
- **RD_ACK**: releases SDA while the host acknowledges.
- **IGNORE**: waits out a transfer that is not addressed to this target, or that the host ended with a NACK.

The transitions are as follows:
- STOP moves any state to IDLE.
- START moves any state to ADDR.
- ADDR moves to ADDR_ACK on a matching address, and to IGNORE otherwise.
- ADDR_ACK moves to WR_DATA or RD_DATA, depending on the direction bit.
- WR_DATA moves to WR_ACK after 8 bits, and WR_ACK moves back to WR_DATA.
- RD_DATA moves to RD_ACK after 8 bits.
- RD_ACK moves back to RD_DATA when the host acknowledges, and to IGNORE when the host sends a NACK.

Each of these moves happens on the SCL falling edge that ends the current phase.

Top module: `qbx_expander`

## Requirements
- R1: After reset, every latch bit is one, so `pin_pull_o` is all zeros. `int_n_o` is high and `sda_pull_o` is low.
- R2: The 7-bit target address is `{ADDR_HI, strap_i}`, which gives 0x20–0x27 with ADDR_HI=4'b0100 and 0x38–0x3F with ADDR_HI=4'b0111. The direction bit is the LSB of the address byte, with 1 meaning read. A matching address is ACKed by pulling SDA low during the ninth clock. Any other address gets a NACK and changes neither the latch nor the interrupt reference.
- R3: A write data byte loads the latch at the start of its ACK phase. `pin_pull_o[i]` is 1 exactly when latch bit i is 0.
- R4: In a 16-pin write, the first data byte loads pins 7:0 and the second loads pins 15:8. In the 8-pin variant, every data byte overwrites the whole latch.
- R5: A read returns the synchronised pin levels, not the latch. A pin that the block pulls low reads as 0.
- R6: A read sends the low byte first, MSB first within each byte. The low byte is captured at the start of the address ACK phase. The high byte is captured at the start of the host's ACK phase for the low byte.
- R7: `int_n_o` goes low, after synchronisation plus one register, while any synchronised pin differs from the interrupt reference. It returns high when the pins match the reference again.
- R8: Each read capture copies the captured pin levels into the interrupt reference, so a completed read deasserts `int_n_o`.
- R9: A STOP or repeated START after the first byte of a 16-pin write abandons the second byte, and the high latch byte keeps its old value.
- R10: The target changes SDA only after an SCL falling edge or a START/STOP. It releases SDA during the host's ACK phase of a read.
- R11: A START in any state restarts address reception, so a repeated START is followed by a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (resolved bus) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 3 | Low three address bits |
| pin_i | input | NUM_PINS | Resolved pin levels |
| pin_pull_o | output | NUM_PINS | 1 pulls the pin low (latch bit is 0) |
| int_n_o | output | 1 | Active-low pin-change interrupt |

## Verification
The bench places two instances on one shared open-drain bus:
- A 16-pin instance with ADDR_HI=4'b0100 and strap 3'b101 (address 0x25). This brings in two-byte ordering, the high-byte capture point and the abandoned second byte.
- An 8-pin instance with ADDR_HI=4'b0111 and strap 3'b010 (address 0x3A). This exercises the alternate address range, whole-latch overwrite by successive bytes, and silence while the other target is addressed.

Pin levels are modelled as the external value ANDed with the inverse of the pull request. Read-back therefore covers both pins that the block drives low and inputs that an outside source drives low.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_DATA,
        S_WR_ACK,
        S_RD_DATA,
        S_RD_ACK,
        S_IGNORE
    } qbx_state_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/qbx_bus_events.sv
module qbx_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    timeunit 1ns;
    timeprecision 1ps;

    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/qbx_target_fsm.sv
module qbx_target_fsm
    import qbx_pkg::*;
#(
    parameter int         NUM_BYTES = 2,
    parameter int         IDX_W     = 1,
    parameter logic [3:0] ADDR_HI   = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              cap_stb,
    output logic [IDX_W-1:0]  cap_idx,
    output logic [IDX_W-1:0]  tx_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [3:0] FULL_CNT = 4'd8;
    localparam logic [3:0] LAST_TX  = 4'd7;

    qbx_state_e        state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [3:0]        bitcnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              rw_q;
    logic              mack_q;
    logic              addr_hit;

    function automatic logic [IDX_W-1:0] nxt_idx(input logic [IDX_W-1:0] i);
        if (i == IDX_W'(NUM_BYTES - 1)) return '0;
        else return i + 1'b1;
    endfunction

    assign addr_hit = (shreg_q[7:1] == {ADDR_HI, strap});

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = S_IDLE;
        end else if (start_det) begin
            state_d = S_ADDR;
        end else begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_ADDR:     if (scl_fall && bitcnt_q == FULL_CNT)
                                state_d = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK: if (scl_fall) state_d = rw_q ? S_RD_DATA : S_WR_DATA;
                S_WR_DATA:  if (scl_fall && bitcnt_q == FULL_CNT) state_d = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) state_d = S_WR_DATA;
                S_RD_DATA:  if (scl_fall && bitcnt_q == LAST_TX) state_d = S_RD_ACK;
                S_RD_ACK:   if (scl_fall) state_d = mack_q ? S_RD_DATA : S_IGNORE;
                S_IGNORE:   state_d = S_IGNORE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // shifter, bit counter, byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            idx_q    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
        end else if (start_det) begin
            bitcnt_q <= '0;
            idx_q    <= '0;
        end else if (stop_det) begin
            bitcnt_q <= '0;
        end else begin
            case (state_q)
                S_ADDR, S_WR_DATA: begin
                    if (scl_rise && bitcnt_q < FULL_CNT) begin
                        shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end
                    if (scl_fall && bitcnt_q == FULL_CNT) begin
                        bitcnt_q <= '0;
                        if (state_q == S_ADDR) rw_q  <= shreg_q[0];
                        else                   idx_q <= nxt_idx(idx_q);
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        idx_q <= '0;
                        if (rw_q) shreg_q <= tx_byte;
                    end
                end
                S_RD_DATA: begin
                    if (scl_fall) begin
                        if (bitcnt_q < LAST_TX) begin
                            shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b1};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else begin
                            bitcnt_q <= '0;
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall && mack_q) begin
                        shreg_q <= tx_byte;
                        idx_q   <= nxt_idx(idx_q);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe  = 1'b0;
        unique case (state_q)
            S_ADDR_ACK, S_WR_ACK: sda_oe = 1'b1;
            S_RD_DATA:            sda_oe = ~shreg_q[BYTE_W-1];
            default:              sda_oe = 1'b0;
        endcase
        wr_stb  = (state_q == S_WR_DATA) && scl_fall && (bitcnt_q == FULL_CNT);
        wr_idx  = idx_q;
        wr_byte = shreg_q;
        cap_stb = ((state_q == S_ADDR) && scl_fall && (bitcnt_q == FULL_CNT)
                    && addr_hit && shreg_q[0])
               || ((state_q == S_RD_DATA) && scl_fall && (bitcnt_q == LAST_TX));
        cap_idx = (state_q == S_ADDR) ? '0 : nxt_idx(idx_q);
        tx_idx  = (state_q == S_ADDR_ACK) ? '0 : nxt_idx(idx_q);
    end

    // R10
    sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R3
    wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !rw_q);

    // R2
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= FULL_CNT);

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state_q == S_ADDR) && (bitcnt_q == 4'd0));
endmodule

// File: rtl/qbx_port_core.sv
module qbx_port_core
    import qbx_pkg::*;
#(
    parameter int NUM_BYTES = 2,
    parameter int IDX_W     = 1,
    localparam int NP       = NUM_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     pins_s,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              cap_stb,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [IDX_W-1:0]  tx_idx,
    output logic [NP-1:0]     latch_q,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              int_n
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NP-1:0] snap_flat;
    logic [NP-1:0] ref_flat;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        logic [BYTE_W-1:0] lat_r, snap_r, ref_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_r  <= '1;
                snap_r <= '1;
                ref_r  <= '1;
            end else begin
                if (wr_stb && wr_idx == IDX_W'(b)) lat_r <= wr_byte;
                if (cap_stb && cap_idx == IDX_W'(b)) begin
                    snap_r <= pins_s[b*BYTE_W +: BYTE_W];
                    ref_r  <= pins_s[b*BYTE_W +: BYTE_W];
                end
            end
        end

        assign latch_q[b*BYTE_W +: BYTE_W]   = lat_r;
        assign snap_flat[b*BYTE_W +: BYTE_W] = snap_r;
        assign ref_flat[b*BYTE_W +: BYTE_W]  = ref_r;
    end

    always_comb begin
        tx_byte = '1;
        for (int b = 0; b < NUM_BYTES; b++)
            if (tx_idx == IDX_W'(b)) tx_byte = snap_flat[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_n <= 1'b1;
        else        int_n <= ~|(pins_s ^ ref_flat);
    end

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(latch_q));

    // R8
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(ref_flat));
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander
    import qbx_pkg::*;
#(
    parameter int         NUM_PINS = 16,
    parameter logic [3:0] ADDR_HI  = 4'b0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_pull_o,
    input  logic [2:0]          strap_i,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pin_pull_o,
    output logic                int_n_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_BYTES = NUM_PINS / BYTE_W;
    localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    logic [1:0]          bus_s;
    logic [NUM_PINS-1:0] pins_s;
    logic [NUM_PINS-1:0] latch_q;
    logic                scl_rise, scl_fall, start_det, stop_det;
    logic                wr_stb, cap_stb;
    logic [IDX_W-1:0]    wr_idx, cap_idx, tx_idx;
    logic [BYTE_W-1:0]   wr_byte, tx_byte;

    qbx_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
    );

    qbx_sync #(.W(NUM_PINS), .RST_VAL({NUM_PINS{1'b1}})) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pins_s)
    );

    qbx_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    qbx_target_fsm #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_s(bus_s[0]), .strap(strap_i), .tx_byte(tx_byte),
        .sda_oe(sda_pull_o),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .cap_stb(cap_stb), .cap_idx(cap_idx), .tx_idx(tx_idx)
    );

    qbx_port_core #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_core (
        .clk(clk), .rst_n(rst_n), .pins_s(pins_s),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .cap_stb(cap_stb), .cap_idx(cap_idx), .tx_idx(tx_idx),
        .latch_q(latch_q), .tx_byte(tx_byte), .int_n(int_n_o)
    );

    assign pin_pull_o = ~latch_q;
endmodule

// File: tb/qbx_expander_bench.sv
module qbx_expander_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q = 16;
    localparam logic [6:0] ADDR_A = 7'h25;
    localparam logic [6:0] ADDR_B = 7'h3A;
    localparam int NV = 6;
    // {latch value, external pin drive}
    localparam logic [31:0] VEC [NV] = '{
        32'hFFFF_A5C3, 32'h00FF_FFFF, 32'hF0F0_0FFF,
        32'h0000_FFFF, 32'h5A3C_FFFF, 32'hFFFF_1234
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, scl_m, sda_m;
    logic [15:0] ext_a, pull_a, pins_a;
    logic [7:0]  ext_b, pull_b, pins_b;
    logic        oe_a, oe_b, int_a, int_b, sda_line;
    int          n_chk = 0;
    int          n_fail = 0;

    assign sda_line = sda_m & ~oe_a & ~oe_b;
    assign pins_a   = ext_a & ~pull_a;
    assign pins_b   = ext_b & ~pull_b;

    qbx_expander #(.NUM_PINS(16), .ADDR_HI(4'b0100)) u_qbx_expander (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(oe_a), .strap_i(3'b101), .pin_i(pins_a),
        .pin_pull_o(pull_a), .int_n_o(int_a)
    );

    qbx_expander #(.NUM_PINS(8), .ADDR_HI(4'b0111)) u_qbx_expander_b (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(oe_b), .strap_i(3'b010), .pin_i(pins_b),
        .pin_pull_o(pull_b), .int_n_o(int_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2); b = sda_line;
        tick(Q/2); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nack, output logic line);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        sda_m = nack; tick(Q); scl_m = 1'b1; tick(Q/2); line = sda_line;
        tick(Q/2); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
    endtask

    task automatic wr_xfer(input logic [6:0] a, input logic [15:0] d, input int nb, output logic aack);
        logic k;
        bus_start();
        send_byte({a, 1'b0}, aack);
        for (int i = 0; i < nb; i++) send_byte(d[i*8 +: 8], k);
        bus_stop();
    endtask

    task automatic rd_xfer(input logic [6:0] a, input int nb, output logic [15:0] d,
                           output logic aack, output logic line);
        logic [7:0] v;
        bus_start();
        send_byte({a, 1'b1}, aack);
        d = '0;
        for (int i = 0; i < nb; i++) begin
            recv_byte(v, (i == nb - 1), line);
            d[i*8 +: 8] = v;
        end
        bus_stop();
    endtask

    initial begin
        tick(190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        logic        ack, line, k;
        logic [15:0] d, lat, ext;

        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; ext_a = '1; ext_b = '1;
        tick(10); rst_n = 1'b1; tick(10);

        // R1 reset state
        chk(pull_a == 16'h0000, "R1 pull A", 32'(pull_a), 32'h0);
        chk(pull_b == 8'h00, "R1 pull B", 32'(pull_b), 32'h0);
        chk(int_a == 1'b1, "R1 int", 32'(int_a), 32'h1);
        chk(sda_line == 1'b1, "R1 sda", 32'(sda_line), 32'h1);

        // vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            lat = VEC[v][31:16];
            ext = VEC[v][15:0];
            ext_a = ext;
            wr_xfer(ADDR_A, lat, 2, ack);
            chk(ack == 1'b1, "R2 addr ack", 32'(ack), 32'h1);
            chk(pull_a == ~lat, "R3 R4 pull", 32'(pull_a), 32'(~lat));
            tick(8);
            rd_xfer(ADDR_A, 2, d, ack, line);
            chk(d == (ext & lat), "R5 R6 read", 32'(d), 32'(ext & lat));
        end
        ext_a = '1;

        // R2 other target silent
        chk(pull_b == 8'h00, "R2 B untouched", 32'(pull_b), 32'h0);

        // R4 byte order
        wr_xfer(ADDR_A, 16'h3412, 2, ack);
        chk(pull_a == ~16'h3412, "R4 order", 32'(pull_a), 32'(~16'h3412));

        // R2 NACK
        wr_xfer(7'h26, 16'h0000, 2, ack);
        chk(ack == 1'b0, "R2 nack", 32'(ack), 32'h0);
        chk(pull_a == ~16'h3412, "R2 no change", 32'(pull_a), 32'(~16'h3412));

        // R9 R11 repeated start after first byte
        bus_start();
        send_byte({ADDR_A, 1'b0}, ack);
        send_byte(8'h00, k);
        rd_xfer(ADDR_A, 2, d, ack, line);
        chk(pull_a == ~16'h3400, "R9 restart", 32'(pull_a), 32'(~16'h3400));
        chk(ack == 1'b1, "R11 readdress", 32'(ack), 32'h1);
        chk(d == 16'h3400, "R11 read", 32'(d), 32'h3400);

        // R9 stop after first byte
        wr_xfer(ADDR_A, 16'hFFC3, 1, ack);
        chk(pull_a == ~16'h34C3, "R9 stop", 32'(pull_a), 32'(~16'h34C3));

        // R4 8-pin overwrite, R2 alternate range
        wr_xfer(ADDR_B, 16'h5F11, 2, ack);
        chk(ack == 1'b1, "R2 alt range", 32'(ack), 32'h1);
        chk(pull_b == 8'hA0, "R4 8-pin", 32'(pull_b), 32'hA0);
        tick(8);
        rd_xfer(ADDR_B, 1, d, ack, line);
        chk(d[7:0] == 8'h5F, "R5 8-pin read", 32'(d[7:0]), 32'h5F);

        // R7 R8 interrupt
        wr_xfer(ADDR_A, 16'hFFFF, 2, ack);
        tick(8);
        rd_xfer(ADDR_A, 2, d, ack, line);
        tick(8);
        chk(int_a == 1'b1, "R8 synced", 32'(int_a), 32'h1);
        ext_a[3] = 1'b0; tick(8);
        chk(int_a == 1'b0, "R7 assert", 32'(int_a), 32'h0);
        ext_a[3] = 1'b1; tick(8);
        chk(int_a == 1'b1, "R7 return", 32'(int_a), 32'h1);
        ext_a[12] = 1'b0; tick(8);
        chk(int_a == 1'b0, "R7 high byte", 32'(int_a), 32'h0);
        rd_xfer(ADDR_A, 2, d, ack, line);
        chk(d == 16'hEFFF, "R5 input low", 32'(d), 32'hEFFF);
        chk(int_a == 1'b1, "R8 cleared", 32'(int_a), 32'h1);
        ext_a[12] = 1'b1; tick(8);
        chk(int_a == 1'b0, "R7 rise", 32'(int_a), 32'h0);
        rd_xfer(ADDR_A, 2, d, ack, line);
        chk(int_a == 1'b1, "R8 cleared again", 32'(int_a), 32'h1);
        chk(line == 1'b1, "R10 released", 32'(line), 32'h1);
        chk(int_b == 1'b1, "R7 B quiet", 32'(int_b), 32'h1);

        report();
    end
endmodule